// File: doc/BRIEF.md
# Machine Cycle Timing Generator

This block sets the length and the qualifying strobes of each processor machine cycle. Every clock period of `clk` stands for one oscillator period. The sequencer requests a cycle by raising `req_valid` with a cycle kind on `req_kind`. The block then walks through one state per oscillator period and drives the address strobe, data strobe, data-direction strobe, memory/IO select, read/write, instruction/operand select and sync lines. It raises `cycle_done` on the last period of the cycle.

An internal cycle takes five periods, or six when the request marks a conditional-branch evaluation. A bus cycle (instruction fetch, operand transfer or I/O transfer) has two address periods followed by a data portion in which `sync_n` is high. The cycle lasts at least five periods. The active-low ready input can stretch the data portion with wait periods. The active-low pause input, used for DMA, can only hold off the start of the next cycle. Once a cycle has started, pause does not affect it.

The FSM has five states. IDLE means no cycle is running. INT is the internal cycle. ADDR covers bus periods 1–2. DATA covers bus periods 3 and later. WAIT is a bus period stretched by ready. The transitions are: START (IDLE or final period to INT/ADDR when a request is accepted), INT_STEP (INT to INT), INT_END (final INT period to IDLE), ADDR_STEP (ADDR to ADDR), ADDR_TO_DATA (ADDR to DATA after period 2), DATA_STEP (DATA to DATA), DATA_TO_WAIT (DATA to WAIT when ready is high at the decision edge), WAIT_HOLD (WAIT to WAIT), WAIT_TO_FINAL (WAIT to a final DATA period when ready is low), and BUS_END (final DATA period to IDLE).

Top module: `mct_machine_cycle`

## Requirements
- R1: After reset, and while the block is idle, the outputs are `busy`=0, `cycle_done`=0, `as_o`=0, `ds_n`=1, `dd_n`=1, `mem_io`=1, `rd_wr_n`=1, `inst_opn`=0 and `sync_n`=0.
- R2: An internal cycle (`req_kind`=0) lasts 5 periods, or 6 periods when `branch_eval` is 1 with the request.
- R3: Throughout an internal cycle `as_o` is 0 and `ds_n`, `dd_n`, `mem_io`, `rd_wr_n` are 1, `sync_n` is 0 and `inst_opn` is 0.
- R4: In a bus cycle (`req_kind` 1, 2 or 3), `as_o` is 1 only in period 1. Periods 1–2 have `sync_n`=0 and `ds_n`=1. From period 3 to the end, `sync_n`=1 and `ds_n`=0. With ready low the cycle lasts exactly 5 periods.
- R5: The qualifiers hold for the whole bus cycle. A fetch (`req_kind`=1) has `inst_opn`=1, `mem_io`=1 and `rd_wr_n`=1, and `req_write` is ignored. An operand transfer (2) has `inst_opn`=0 and `mem_io`=1. An I/O transfer (3) has `mem_io`=0. For kinds 2 and 3, `rd_wr_n` is the inverse of `req_write`, and `dd_n` is 0 in the data portion of a write, otherwise 1.
- R6: `rdy_n` is sampled at the clock edge that opens period 5 and at each later edge. Each high sample adds one wait period. The period after the first low sample is the final one, so a bus cycle lasts 5 + (number of consecutive high samples) periods.
- R7: `rdy_n` is ignored on internal cycles. They are never extended.
- R8: `cycle_done` is 1 for exactly the final period of each cycle. A request present during that period starts the next cycle in the following period with no idle gap.
- R9: A low `pause_n` stops a request from being accepted, whether the block is idle or in the final period. A low `pause_n` during any other period of a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request from the sequencer |
| req_kind | input | 2 | 0 internal, 1 fetch, 2 operand, 3 I/O |
| req_write | input | 1 | Write direction for operand and I/O cycles |
| branch_eval | input | 1 | Internal cycle evaluates a branch condition (6 periods) |
| rdy_n | input | 1 | Active-low ready, stretches the data portion |
| pause_n | input | 1 | Active-low DMA pause, holds off the next cycle |
| as_o | output | 1 | Address strobe |
| ds_n | output | 1 | Data strobe, active low |
| dd_n | output | 1 | Data-direction strobe, low while driving write data |
| mem_io | output | 1 | 1 memory, 0 I/O |
| rd_wr_n | output | 1 | 1 read, 0 write |
| inst_opn | output | 1 | 1 instruction fetch, 0 otherwise |
| sync_n | output | 1 | High during the data portion of a bus cycle |
| cycle_done | output | 1 | Final period of the current cycle |
| busy | output | 1 | A machine cycle is in progress |

## Verification
The bench sweeps every cycle kind, both branch settings, both directions and zero to four wait samples, and checks every strobe in every period against values computed from the period number. It aims at the ready decision edge: a design that sampled ready one edge early or late would come out one period too long or too short, or would stretch a zero-wait cycle. It drives ready high during internal cycles, where a design that failed to ignore it would stretch them. It drops pause partway through a cycle, where a wrong design would cut the cycle off, and holds pause low across a final period, where a wrong design would chain the next cycle anyway. Back-to-back requests expose an idle bubble or a `cycle_done` that stays high into the next cycle.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [1:0] {
        CK_INT   = 2'd0,
        CK_FETCH = 2'd1,
        CK_OPND  = 2'd2,
        CK_IO    = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_INT  = 3'd1,
        S_ADDR = 3'd2,
        S_DATA = 3'd3,
        S_WAIT = 3'd4
    } tstate_e;

    typedef struct packed {
        logic as_o;
        logic ds_n;
        logic dd_n;
        logic mem_io;
        logic rd_wr_n;
        logic inst_opn;
        logic sync_n;
        logic busy;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{
        as_o: 1'b0, ds_n: 1'b1, dd_n: 1'b1, mem_io: 1'b1,
        rd_wr_n: 1'b1, inst_opn: 1'b0, sync_n: 1'b0, busy: 1'b0
    };

endpackage

// File: rtl/mct_start_gate.sv
module mct_start_gate (
    input  logic req_valid,
    input  logic pause_n,
    input  logic idle,
    input  logic final_prd,
    output logic go
);
    // A new cycle may only begin at a cycle boundary, and never while paused.
    always_comb begin
        go = req_valid && pause_n && (idle || final_prd);
    end
endmodule

// File: rtl/mct_len_calc.sv
module mct_len_calc #(
    parameter int BASE_PRDS   = 5,
    parameter int BRANCH_XTRA = 1,
    parameter int CNT_W       = 3
) (
    input  logic             branch,
    output logic [CNT_W-1:0] int_len
);
    localparam logic [CNT_W-1:0] LEN_PLAIN  = CNT_W'(BASE_PRDS);
    localparam logic [CNT_W-1:0] LEN_BRANCH = CNT_W'(BASE_PRDS + BRANCH_XTRA);

    always_comb begin
        int_len = branch ? LEN_BRANCH : LEN_PLAIN;
    end
endmodule

// File: rtl/mct_strobe_dec.sv
module mct_strobe_dec
    import mct_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  tstate_e          st,
    input  logic [CNT_W-1:0] prd,
    input  cyc_kind_e        kind,
    input  logic             wr,
    output strobe_t          stb
);
    logic active;
    logic data_prt;

    always_comb begin
        active   = (st != S_IDLE);
        data_prt = (st == S_DATA) || (st == S_WAIT);

        stb          = STROBE_IDLE;
        stb.busy     = active;
        stb.as_o     = (st == S_ADDR) && (prd == CNT_W'(1));
        stb.sync_n   = data_prt;
        stb.ds_n     = !data_prt;
        stb.dd_n     = !(data_prt && wr);
        stb.mem_io   = !(active && (st != S_INT) && (kind == CK_IO));
        stb.rd_wr_n  = !(active && (st != S_INT) && wr);
        stb.inst_opn = active && (st != S_INT) && (kind == CK_FETCH);
    end
endmodule

// File: rtl/mct_machine_cycle.sv
module mct_machine_cycle
    import mct_pkg::*;
#(
    parameter int ADDR_PRDS   = 2,
    parameter int BASE_PRDS   = 5,
    parameter int BRANCH_XTRA = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       req_write,
    input  logic       branch_eval,
    input  logic       rdy_n,
    input  logic       pause_n,
    output logic       as_o,
    output logic       ds_n,
    output logic       dd_n,
    output logic       mem_io,
    output logic       rd_wr_n,
    output logic       inst_opn,
    output logic       sync_n,
    output logic       cycle_done,
    output logic       busy
);
    // The ready decision edge closes the period before BASE_PRDS, so the
    // address portion must end before that period.
    localparam int CNT_W = $clog2(BASE_PRDS + BRANCH_XTRA + 1);
    localparam logic [CNT_W-1:0] PRD_ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] PRD_ADDR   = CNT_W'(ADDR_PRDS);
    localparam logic [CNT_W-1:0] PRD_DECIDE = CNT_W'(BASE_PRDS - 1);
    localparam logic [CNT_W-1:0] PRD_BASE   = CNT_W'(BASE_PRDS);

    tstate_e          st_q, st_nx;
    logic [CNT_W-1:0] prd_q, prd_nx;
    cyc_kind_e        kind_q, kind_nx;
    logic             wr_q, wr_nx;
    logic             br_q, br_nx;
    logic             fin_q, fin_nx;
    logic             go;
    logic [CNT_W-1:0] int_len;
    strobe_t          stb_nx, stb_q;
    cyc_kind_e        req_kind_e;

    assign req_kind_e = cyc_kind_e'(req_kind);

    mct_start_gate u_gate (
        .req_valid (req_valid),
        .pause_n   (pause_n),
        .idle      (st_q == S_IDLE),
        .final_prd (fin_q),
        .go        (go)
    );

    mct_len_calc #(
        .BASE_PRDS   (BASE_PRDS),
        .BRANCH_XTRA (BRANCH_XTRA),
        .CNT_W       (CNT_W)
    ) u_len (
        .branch  (br_q),
        .int_len (int_len)
    );

    // Next-state logic: one step per oscillator period.
    always_comb begin
        st_nx   = st_q;
        prd_nx  = prd_q;
        kind_nx = kind_q;
        wr_nx   = wr_q;
        br_nx   = br_q;
        fin_nx  = 1'b0;

        if (go) begin
            // START
            kind_nx = req_kind_e;
            wr_nx   = req_write && (req_kind_e == CK_OPND || req_kind_e == CK_IO);
            br_nx   = branch_eval && (req_kind_e == CK_INT);
            prd_nx  = PRD_ONE;
            st_nx   = (req_kind_e == CK_INT) ? S_INT : S_ADDR;
        end else if (fin_q) begin
            // INT_END / BUS_END
            st_nx  = S_IDLE;
            prd_nx = '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    st_nx = S_IDLE;
                end
                S_INT: begin
                    // INT_STEP; rdy_n has no influence here
                    prd_nx = prd_q + PRD_ONE;
                    fin_nx = ((prd_q + PRD_ONE) == int_len);
                end
                S_ADDR: begin
                    prd_nx = prd_q + PRD_ONE;
                    if (prd_q == PRD_ADDR) begin
                        st_nx = S_DATA;          // ADDR_TO_DATA
                    end
                end
                S_DATA: begin
                    if (prd_q == PRD_DECIDE) begin
                        prd_nx = PRD_BASE;
                        if (rdy_n) begin
                            st_nx = S_WAIT;      // DATA_TO_WAIT
                        end else begin
                            fin_nx = 1'b1;       // final period 5
                        end
                    end else begin
                        prd_nx = prd_q + PRD_ONE; // DATA_STEP
                    end
                end
                S_WAIT: begin
                    if (!rdy_n) begin
                        st_nx  = S_DATA;         // WAIT_TO_FINAL
                        fin_nx = 1'b1;
                    end
                end
                default: begin
                    st_nx = S_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            prd_q  <= '0;
            kind_q <= CK_INT;
            wr_q   <= 1'b0;
            br_q   <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            st_q   <= st_nx;
            prd_q  <= prd_nx;
            kind_q <= kind_nx;
            wr_q   <= wr_nx;
            br_q   <= br_nx;
            fin_q  <= fin_nx;
        end
    end

    mct_strobe_dec #(
        .CNT_W (CNT_W)
    ) u_dec (
        .st   (st_nx),
        .prd  (prd_nx),
        .kind (kind_nx),
        .wr   (wr_nx),
        .stb  (stb_nx)
    );

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= STROBE_IDLE;
        end else begin
            stb_q <= stb_nx;
        end
    end

    assign as_o       = stb_q.as_o;
    assign ds_n       = stb_q.ds_n;
    assign dd_n       = stb_q.dd_n;
    assign mem_io     = stb_q.mem_io;
    assign rd_wr_n    = stb_q.rd_wr_n;
    assign inst_opn   = stb_q.inst_opn;
    assign sync_n     = stb_q.sync_n;
    assign busy       = stb_q.busy;
    assign cycle_done = fin_q;

endmodule

// File: rtl/mct_chk.sv
module mct_chk
    import mct_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pause_n,
    input logic      busy,
    input logic      cycle_done,
    input logic      as_o,
    input logic      ds_n,
    input logic      dd_n,
    input logic      mem_io,
    input logic      rd_wr_n,
    input logic      inst_opn,
    input logic      sync_n,
    input cyc_kind_e kind_q
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !cycle_done));                           // R1

    AST_INT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == CK_INT) |-> (!as_o && ds_n && dd_n && mem_io && !sync_n)); // R3

    AST_DS_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> (sync_n && busy && !as_o));                         // R4

    AST_FETCH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == CK_FETCH) |-> (inst_opn && mem_io && rd_wr_n)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);                                  // R8

    AST_NO_MIDCYCLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_done) |=> busy);                              // R9

    AST_PAUSE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && !pause_n) |=> !busy);                          // R9

endmodule

bind mct_machine_cycle mct_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_n    (pause_n),
    .busy       (busy),
    .cycle_done (cycle_done),
    .as_o       (as_o),
    .ds_n       (ds_n),
    .dd_n       (dd_n),
    .mem_io     (mem_io),
    .rd_wr_n    (rd_wr_n),
    .inst_opn   (inst_opn),
    .sync_n     (sync_n),
    .kind_q     (kind_q)
);

// File: tb/sim_mct_machine_cycle.sv
`timescale 1ns/1ps
module sim_mct_machine_cycle;

    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_write = 1'b0;
    logic       branch_eval = 1'b0;
    logic       rdy_n = 1'b0;
    logic       pause_n = 1'b1;
    logic       as_o, ds_n, dd_n, mem_io, rd_wr_n, inst_opn, sync_n, cycle_done, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mct_machine_cycle u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .branch_eval(branch_eval), .rdy_n(rdy_n),
        .pause_n(pause_n), .as_o(as_o), .ds_n(ds_n), .dd_n(dd_n),
        .mem_io(mem_io), .rd_wr_n(rd_wr_n), .inst_opn(inst_opn),
        .sync_n(sync_n), .cycle_done(cycle_done), .busy(busy)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Idle outputs (R1).
    task automatic check_idle(input string req);
        chk(req, "busy", busy, 0);
        chk(req, "cycle_done", cycle_done, 0);
        chk(req, "idle strobes", {as_o, ds_n, dd_n, mem_io, rd_wr_n, inst_opn, sync_n},
            {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    endtask

    // Expected strobes of period p (1-based) for a cycle of kind k.
    task automatic check_period(input int k, input bit wr, input int p, input int len);
        logic [6:0] exp;
        bit dp;
        bit wv;
        dp = (p >= 3);
        wv = wr && (k >= 2);
        if (k == 0) begin
            exp = {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
            chk("R3", "internal strobes", {as_o, ds_n, dd_n, mem_io, rd_wr_n, inst_opn, sync_n}, exp);
        end else begin
            chk("R4", "as/sync/ds", {as_o, sync_n, ds_n}, {(p == 1), dp, !dp});
            exp = {(k != 3), !wv, (k == 1), !(dp && wv)};
            chk("R5", "mem_io/rd_wr_n/inst_opn/dd_n", {mem_io, rd_wr_n, inst_opn, dd_n}, exp);
        end
        chk("R8", "busy", busy, 1);
        chk((k == 0) ? "R2" : "R6", "cycle_done", cycle_done, (p == len));
    endtask

    // One isolated cycle; starts and ends on a falling edge with the block idle.
    task automatic run_cycle(input int k, input bit br, input bit wr, input int waits);
        int len;
        len = (k == 0) ? (5 + br) : (5 + waits);
        req_valid = 1'b1;
        req_kind = k[1:0];
        branch_eval = br;
        req_write = wr;
        rdy_n = (k == 0);
        for (int p = 1; p <= len; p++) begin
            @(negedge clk);
            check_period(k, wr, p, len);
            req_valid = 1'b0;
            // Internal cycles see ready high throughout (R7).
            if (k == 0) rdy_n = 1'b1;
            else        rdy_n = (p >= 4) && (p < 4 + waits);
        end
        @(negedge clk);
        check_idle((k == 0) ? "R7" : "R6");
        rdy_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // Sweep of kinds, branch, direction and wait counts (R2, R4, R5, R6, R7).
        for (int k = 0; k < 4; k++)
            for (int br = 0; br < 2; br++)
                for (int wr = 0; wr < 2; wr++)
                    for (int w = 0; w < 5; w++)
                        run_cycle(k, br[0], wr[0], w);

        // Back-to-back: internal then fetch with no gap (R8).
        req_valid = 1'b1; req_kind = 2'd0; branch_eval = 1'b0; req_write = 1'b0; rdy_n = 1'b0;
        for (int p = 1; p <= 4; p++) @(negedge clk);
        req_kind = 2'd1;
        @(negedge clk);
        chk("R8", "done on final", cycle_done, 1);
        @(negedge clk);
        chk("R8", "chained busy", busy, 1);
        chk("R8", "chained done low", cycle_done, 0);
        chk("R8", "chained as", as_o, 1);
        chk("R8", "chained fetch", inst_opn, 1);
        req_valid = 1'b0;
        for (int p = 2; p <= 5; p++) @(negedge clk);
        chk("R8", "fetch done", cycle_done, 1);
        @(negedge clk);
        check_idle("R8");

        // Pause while idle holds off the request (R9).
        pause_n = 1'b0; req_valid = 1'b1; req_kind = 2'd2; req_write = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "held off idle", busy, 0);
        end
        pause_n = 1'b1;
        @(negedge clk);
        chk("R9", "start after release", {busy, as_o}, 2'b11);
        // Pause mid-cycle has no effect; pause on final period blocks chaining.
        pause_n = 1'b0;
        for (int p = 2; p <= 5; p++) begin
            @(negedge clk);
            chk("R9", "mid-cycle busy", busy, 1);
            chk("R9", "mid-cycle done", cycle_done, (p == 5));
        end
        @(negedge clk);
        chk("R9", "no chain while paused", busy, 0);
        @(negedge clk);
        chk("R9", "still held", busy, 0);
        pause_n = 1'b1;
        @(negedge clk);
        chk("R9", "resume", {busy, as_o, rd_wr_n}, 3'b110);
        req_valid = 1'b0;
        for (int p = 2; p <= 5; p++) @(negedge clk);
        @(negedge clk);
        check_idle("R9");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule